// File: doc/BRIEF.md
# Packet Page Data Window

This block lets a host reach a buffer of packet pages, each 2048 bytes, one byte at a time through a narrow register window. The host first loads a 16-bit pointer as two separate byte writes. The pointer chooses the page, the byte offset within that page, and the addressing mode. The host then reads or writes any of four data-port addresses, and each access lands on one byte of page storage.

Two pointer flags shape every data access. The top bit chooses the page. When it is set, the page is the one at the head of the receive queue. When it is clear, the page is the one the host put in the packet number register. Both page numbers come in as inputs. Bit 14 chooses the offset mode. In auto-advance mode the pointer offset steps by one after each access. In direct mode the low two bits of the data-port address are added to a fixed pointer offset. Read data comes from synchronous storage and is registered, so it appears one cycle after the read strobe.

Top module: `pkt_window`

## Requirements
- R1: After reset the pointer is 0x0000, and reading both pointer bytes returns 0x00.
- R2: A write to address 6 loads pointer bits 7:0 and leaves bits 15:8 unchanged. A write to address 7 loads bits 15:8 and leaves bits 7:0 unchanged.
- R3: A read of address 6 returns pointer bits 7:0. A read of address 7 returns pointer bits 15:8 ANDed with 0xF7, so bit 3 of that byte reads as 0.
- R4: For a data access, pointer bit 15 = 1 selects the page on `rx_head_page`, and bit 15 = 0 selects the page on `pkt_num`.
- R5: Pointer bits 10:0 give the byte offset within the selected 2048-byte page.
- R6: When pointer bit 14 = 1, the access uses the pointer offset as it stands. On the same clock edge the offset becomes (offset + 1) mod 2048, and bits 15:11 stay unchanged. So 0x77FF becomes 0x7000.
- R7: When pointer bit 14 = 0, the byte address is (offset + addr[1:0]) mod 2048, and the pointer is not modified.
- R8: Data-port addresses 8, 9, 10 and 11 all reach the same window.
- R9: Read data is registered. It is valid on `rdata` one cycle after the read strobe and holds until the next read.
- R10: When `wr_en` and `rd_en` are both high, only the write takes place. Writes to addresses other than 6 through 11 change nothing, and reads of them return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe |
| rd_en | input | 1 | Host read strobe |
| addr | input | AW (4) | Host byte address |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Registered read data |
| rx_head_page | input | PG_W (1) | Page at the head of the receive queue |
| pkt_num | input | PG_W (1) | Page held in the packet number register |

## Verification
A pointer write, or a data access in auto-advance mode, changes the pointer on the same edge that samples the strobe. A pointer readback started at the next falling edge therefore already sees the new value. Read data is registered on the edge that samples `rd_en`, so the bench drives each strobe on a falling edge and samples `rdata` on the following falling edge, one cycle later. Memory contents are checked only through later data-port reads, with the pointer reloaded in between. This keeps every expected value tied to the port timing rather than to internal state.

// File: rtl/pkt_window.sv
module pkt_window #(
  parameter int PAGES = 2,
  parameter int OFS_W = 11,
  parameter int AW    = 4,
  localparam int PG_W  = $clog2(PAGES),
  localparam int DEPTH = PAGES << OFS_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic            rd_en,
  input  logic [AW-1:0]   addr,
  input  logic [7:0]      wdata,
  output logic [7:0]      rdata,
  input  logic [PG_W-1:0] rx_head_page,
  input  logic [PG_W-1:0] pkt_num
);
  localparam logic [AW-1:0] A_PLO = AW'(6);
  localparam logic [AW-1:0] A_PHI = AW'(7);
  localparam logic [AW-3:0] A_DAT = (AW-2)'(2);

  logic [15:0] ptr_q;
  logic [7:0]  mem [DEPTH];

  logic is_data, rd_go, acc, wr_acc, auto_inc;
  logic [PG_W-1:0] page;
  logic [OFS_W-1:0] ofs_base, ofs;
  logic [PG_W+OFS_W-1:0] idx;

  assign is_data  = addr[AW-1:2] == A_DAT;
  assign rd_go    = rd_en & ~wr_en;
  assign wr_acc   = wr_en & is_data;
  assign acc      = (wr_en | rd_en) & is_data;
  assign auto_inc = ptr_q[14];
  assign page     = ptr_q[15] ? rx_head_page : pkt_num;
  assign ofs_base = ptr_q[OFS_W-1:0];
  assign ofs      = auto_inc ? ofs_base : ofs_base + OFS_W'(addr[1:0]);
  assign idx      = {page, ofs};

  always_ff @(posedge clk) begin
    if (!rst_n)
      ptr_q <= '0;
    else if (wr_en && addr == A_PLO)
      ptr_q[7:0] <= wdata;
    else if (wr_en && addr == A_PHI)
      ptr_q[15:8] <= wdata;
    else if (acc && auto_inc)
      ptr_q[OFS_W-1:0] <= ofs_base + OFS_W'(1);
  end

  always_ff @(posedge clk)
    if (wr_acc) mem[idx] <= wdata;

  always_ff @(posedge clk) begin
    if (!rst_n)
      rdata <= '0;
    else if (rd_go) begin
      if (is_data)             rdata <= mem[idx];
      else if (addr == A_PLO)  rdata <= ptr_q[7:0];
      else if (addr == A_PHI)  rdata <= ptr_q[15:8] & 8'hF7;
      else                     rdata <= 8'h00;
    end
  end
endmodule

// File: rtl/pkt_window_chk.sv
module pkt_window_chk #(
  parameter int AW    = 4,
  parameter int OFS_W = 11
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic          rd_en,
  input logic [AW-1:0] addr,
  input logic [7:0]    wdata,
  input logic [7:0]    rdata,
  input logic [15:0]   ptr
);
  logic dacc;
  assign dacc = (wr_en | rd_en) && addr >= AW'(8) && addr <= AW'(11);

  // R6
  ptr_autoinc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dacc && ptr[14] |=> ptr[OFS_W-1:0] == OFS_W'($past(ptr[OFS_W-1:0]) + 1)
                        && ptr[15:OFS_W] == $past(ptr[15:OFS_W]));

  // R7
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dacc && !ptr[14] |=> $stable(ptr));

  // R2
  ptr_lo_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && addr == AW'(6) |=> ptr[7:0] == $past(wdata) && $stable(ptr[15:8]));

  // R2
  ptr_hi_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && addr == AW'(7) |=> ptr[15:8] == $past(wdata) && $stable(ptr[7:0]));

  // R3
  hi_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && !wr_en && addr == AW'(7) |=> rdata == ($past(ptr[15:8]) & 8'hF7));

  // R9
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && !wr_en) |=> $stable(rdata));
endmodule

bind pkt_window pkt_window_chk #(.AW(AW), .OFS_W(OFS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .wdata(wdata), .rdata(rdata), .ptr(ptr_q)
);

// File: tb/pkt_window_tb.sv
module pkt_window_tb;
  localparam int CLK_P = 10;

  logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic [0:0] rx_head_page = '0, pkt_num = '0;
  int n_run = 0, n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  pkt_window u_dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata),
    .rx_head_page(rx_head_page), .pkt_num(pkt_num));

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); rd_en = 1; addr = a;
    @(negedge clk); rd_en = 0; d = rdata;
  endtask

  task automatic set_ptr(input logic [15:0] v);
    wr(4'd6, v[7:0]); wr(4'd7, v[15:8]);
  endtask

  task automatic chk_ptr(input string tag, input logic [15:0] exp);
    logic [7:0] d;
    rd(4'd6, d); chk({tag, " lo"}, d, exp[7:0]);
    rd(4'd7, d); chk({tag, " hi"}, d, exp[15:8] & 8'hF7);
  endtask

  task automatic t_reset;
    chk_ptr("R1 reset pointer", 16'h0000);
  endtask

  task automatic t_ptr_bytes;
    wr(4'd6, 8'h34); wr(4'd7, 8'h12);
    chk_ptr("R2 pointer load", 16'h1234);
    wr(4'd6, 8'h56);
    chk_ptr("R2 low write keeps high", 16'h1256);
    wr(4'd7, 8'h21);
    chk_ptr("R2 high write keeps low", 16'h2156);
  endtask

  task automatic t_hi_mask;
    logic [7:0] d;
    set_ptr(16'hFFFF);
    rd(4'd7, d); chk("R3 high byte mask", d, 8'hF7);
    rd(4'd6, d); chk("R3 low byte full", d, 8'hFF);
  endtask

  task automatic t_autoinc;
    logic [7:0] d;
    pkt_num = 1'b1;
    set_ptr(16'h4010);
    wr(4'd8, 8'hA0); wr(4'd9, 8'hA1); wr(4'd10, 8'hA2); wr(4'd11, 8'hA3);
    chk_ptr("R6 four increments", 16'h4014);
    set_ptr(16'h4010);
    for (int i = 0; i < 4; i++) begin
      rd(4'(8 + i), d);
      chk("R8 R5 autoinc readback", d, 8'(8'hA0 + i));
    end
    chk_ptr("R6 read increments", 16'h4014);
  endtask

  task automatic t_offset;
    logic [7:0] d;
    pkt_num = 1'b1;
    set_ptr(16'h0020);
    wr(4'd9, 8'hAA); wr(4'd11, 8'hBB);
    chk_ptr("R7 pointer unchanged by writes", 16'h0020);
    rd(4'd9, d); chk("R7 offset read +1", d, 8'hAA);
    rd(4'd11, d); chk("R7 offset read +3", d, 8'hBB);
    chk_ptr("R7 pointer unchanged by reads", 16'h0020);
    set_ptr(16'h4021);
    rd(4'd8, d); chk("R7 offset byte seen by autoinc", d, 8'hAA);
    set_ptr(16'h07FF);
    wr(4'd11, 8'hC3);
    set_ptr(16'h4002);
    rd(4'd10, d); chk("R7 offset sum wraps", d, 8'hC3);
  endtask

  task automatic t_page_sel;
    logic [7:0] d;
    pkt_num = 1'b1; set_ptr(16'h4000); wr(4'd8, 8'h11);
    rx_head_page = 1'b0; pkt_num = 1'b1;
    set_ptr(16'hC000); wr(4'd8, 8'h5A);
    set_ptr(16'h4000); pkt_num = 1'b1;
    rd(4'd8, d); chk("R4 page one untouched", d, 8'h11);
    set_ptr(16'h4000); pkt_num = 1'b0;
    rd(4'd8, d); chk("R4 rx head page written", d, 8'h5A);
    rx_head_page = 1'b1; pkt_num = 1'b0;
    set_ptr(16'hC000);
    rd(4'd8, d); chk("R4 rx head selects page one", d, 8'h11);
  endtask

  task automatic t_wrap;
    logic [7:0] d;
    pkt_num = 1'b0;
    set_ptr(16'h77FF);
    wr(4'd10, 8'h99);
    chk_ptr("R6 wrap keeps 15:11", 16'h7000);
    set_ptr(16'h47FF);
    rd(4'd8, d); chk("R6 byte at 0x7FF", d, 8'h99);
    chk_ptr("R6 read wrap", 16'h4000);
  endtask

  task automatic t_ignored;
    logic [7:0] d;
    set_ptr(16'h0123);
    wr(4'd3, 8'hEE); wr(4'd12, 8'hEE);
    chk_ptr("R10 other writes ignored", 16'h0123);
    rd(4'd2, d); chk("R10 other read zero", d, 8'h00);
    rd(4'd6, d);
    @(negedge clk); wr_en = 1; rd_en = 1; addr = 4'd7; wdata = 8'h44;
    @(negedge clk); wr_en = 0; rd_en = 0;
    chk("R10 R9 rdata held on write priority", rdata, 8'h23);
    chk_ptr("R10 write priority", 16'h4423);
  endtask

  initial begin
    #(CLK_P * 100000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_ptr_bytes();
    t_hi_mask();
    t_autoinc();
    t_offset();
    t_page_sel();
    t_wrap();
    t_ignored();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule